// File: doc/BRIEF.md
# Video Bus Pattern and Nametable Mapper

This block sits between the video processor's 14-bit address bus and two memories: the cartridge pattern RAM, which is banked in 8 kB pages, and the console's internal nametable RAM. It is purely combinational. The bank register lives elsewhere and supplies a 2-bit page number and a one-screen select bit. Static board straps choose how the nametables are mirrored. A further strap enables a four-screen arrangement, in which the cartridge RAM serves every nametable and the console RAM is switched off.

In the normal arrangement, addresses below $2000 reach the banked pattern RAM. Addresses at $2000 and above reach the console RAM, and its A10 line comes from video A10 (vertical), video A11 (horizontal) or the register's select bit (one-screen). In the four-screen arrangement, video A13 is ORed into each page-number line. Everything from $2000 upward therefore lands in the last 8 kB page. That page holds four separate nametables and, at $3000 and above, a plain scratch area. If the register also selects page 3, pattern fetches alias that same memory. This is the only way to reach its top 256 bytes.

Boards fitted with less pattern RAM use the parameter `CHR_BANK_BITS`. Page-address lines that are not fitted are held high.

Top module: `vbus_chr_nt_map`

## Requirements
- R1: `chr_addr[12:0]` always equals `vaddr[12:0]`.
- R2: Outside four-screen mode, `chr_addr[14:13]` equals `bank_sel` for every address.
- R3: With `mirror_strap` = 2'b00 (vertical), `nt_a10` equals `vaddr[10]`.
- R4: With `mirror_strap` = 2'b01 (horizontal), `nt_a10` equals `vaddr[11]`.
- R5: With `mirror_strap[1]` = 1 (one-screen, both codes 2'b10 and 2'b11), `nt_a10` equals `one_scr_sel` and does not depend on `vaddr`.
- R6: Outside four-screen mode, `vaddr[13]` = 0 gives `chr_ce_n` = 0 and `nt_ce_n` = 1, and `vaddr[13]` = 1 gives `chr_ce_n` = 1 and `nt_ce_n` = 0. The two enables are never both active (low).
- R7: With `four_scr_strap` = 1, `chr_ce_n` is 0 and `nt_ce_n` is 1 for every address.
- R8: With `four_scr_strap` = 1 and `vaddr[13]` = 1, `chr_addr[14:13]` is 2'b11 whatever `bank_sel` holds. $2000, $2400, $2800, $2C00 and $3000 therefore reach five distinct RAM locations.
- R9: With `four_scr_strap` = 1, pattern addresses use `bank_sel`. With `bank_sel` = 2'b11, pattern address X and address X+$2000 reach the same RAM location, and addresses $1F00-$1FFF reach RAM $7F00-$7FFF.
- R10: When `CHR_BANK_BITS` is less than 2, the page-address lines at and above bit `13+CHR_BANK_BITS` are 1. This holds in either mode and for any `bank_sel`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| vaddr | input | 14 | Video processor address bus |
| bank_sel | input | 2 | Pattern page number from the bank register |
| one_scr_sel | input | 1 | One-screen nametable select from the bank register |
| mirror_strap | input | 2 | Mirroring strap: 00 vertical, 01 horizontal, 1x one-screen |
| four_scr_strap | input | 1 | Four-screen strap: cartridge RAM serves the nametables |
| chr_addr | output | 15 | Cartridge pattern RAM address |
| chr_ce_n | output | 1 | Cartridge pattern RAM enable, active low |
| nt_a10 | output | 1 | Console nametable RAM A10 line |
| nt_ce_n | output | 1 | Console nametable RAM enable, active low |

## Verification
The block holds no state. A fault in its page folding or strap decode shows up at the ports as soon as the inputs settle. It appears as a wrong page number on `chr_addr`, or as two enables that are active together or both idle. A wrong mirroring source appears only on addresses whose A10 and A11 bits differ. The bench therefore walks addresses chosen so that every candidate source gives a different answer. It also checks the aliasing corner of four-screen mode at page 3 and the tied-high lines on smaller configurations.

// File: rtl/vbus_chr_nt_map_pkg.sv
package vbus_chr_nt_map_pkg;

  typedef enum logic [1:0] {
    MIR_VERT    = 2'b00,
    MIR_HORIZ   = 2'b01,
    MIR_ONE     = 2'b10,
    MIR_ONE_ALT = 2'b11
  } mirror_mode_e;

  // Picks the nametable A10 source for a given strap setting.
  function automatic logic pick_nt_a10(input mirror_mode_e mode,
                                       input logic va10,
                                       input logic va11,
                                       input logic sel);
    logic r;
    unique case (mode)
      MIR_VERT:  r = va10;
      MIR_HORIZ: r = va11;
      default:   r = sel;
    endcase
    return r;
  endfunction

  // One page-address line: a fitted line ORs the register bit with the fold
  // term, and an unfitted line is held high.
  function automatic logic page_line(input logic fitted,
                                     input logic reg_bit,
                                     input logic fold);
    return fitted ? (reg_bit | fold) : 1'b1;
  endfunction

endpackage

// File: rtl/vbus_page_addr.sv
module vbus_page_addr
  import vbus_chr_nt_map_pkg::*;
#(
  parameter int PAGE_AW       = 13,
  parameter int MAX_BANK_BITS = 2,
  parameter int CHR_BANK_BITS = 2,
  localparam int CHR_AW       = PAGE_AW + MAX_BANK_BITS
) (
  input  logic [PAGE_AW-1:0]       offset,
  input  logic [MAX_BANK_BITS-1:0] bank,
  input  logic                     fold,
  output logic [CHR_AW-1:0]        addr
);

  assign addr[PAGE_AW-1:0] = offset;

  for (genvar i = 0; i < MAX_BANK_BITS; i++) begin : g_line
    if (i < CHR_BANK_BITS) begin : g_fit
      assign addr[PAGE_AW+i] = page_line(1'b1, bank[i], fold);
    end else begin : g_tie
      logic unused_bit;
      assign unused_bit        = bank[i] ^ fold;
      assign addr[PAGE_AW+i]   = page_line(1'b0, unused_bit, fold);
    end
  end

endmodule

// File: rtl/vbus_nt_mirror.sv
module vbus_nt_mirror
  import vbus_chr_nt_map_pkg::*;
(
  input  logic       va10,
  input  logic       va11,
  input  logic       sel,
  input  logic [1:0] strap,
  output logic       a10
);

  mirror_mode_e mode;

  always_comb begin
    mode = mirror_mode_e'(strap);
    a10  = pick_nt_a10(mode, va10, va11, sel);
  end

endmodule

// File: rtl/vbus_ce_decode.sv
module vbus_ce_decode (
  input  logic va13,
  input  logic four_scr,
  output logic chr_ce_n,
  output logic nt_ce_n
);

  // In four-screen mode the cartridge RAM serves the whole bus.
  always_comb begin
    if (four_scr) begin
      chr_ce_n = 1'b0;
      nt_ce_n  = 1'b1;
    end else begin
      chr_ce_n = va13;
      nt_ce_n  = ~va13;
    end
  end

endmodule

// File: rtl/vbus_chr_nt_map.sv
module vbus_chr_nt_map
  import vbus_chr_nt_map_pkg::*;
#(
  parameter int VA_W          = 14,
  parameter int PAGE_AW       = 13,
  parameter int MAX_BANK_BITS = 2,
  parameter int CHR_BANK_BITS = 2,
  localparam int CHR_AW       = PAGE_AW + MAX_BANK_BITS
) (
  input  logic [VA_W-1:0]          vaddr,
  input  logic [MAX_BANK_BITS-1:0] bank_sel,
  input  logic                     one_scr_sel,
  input  logic [1:0]               mirror_strap,
  input  logic                     four_scr_strap,
  output logic [CHR_AW-1:0]        chr_addr,
  output logic                     chr_ce_n,
  output logic                     nt_a10,
  output logic                     nt_ce_n
);

  // Named internal events, kept visible for the checker.
  logic nt_window;
  logic page_fold;

  assign nt_window = vaddr[PAGE_AW];
  assign page_fold = four_scr_strap & nt_window;

  vbus_page_addr #(
    .PAGE_AW      (PAGE_AW),
    .MAX_BANK_BITS(MAX_BANK_BITS),
    .CHR_BANK_BITS(CHR_BANK_BITS)
  ) u_page (
    .offset(vaddr[PAGE_AW-1:0]),
    .bank  (bank_sel),
    .fold  (page_fold),
    .addr  (chr_addr)
  );

  vbus_nt_mirror u_mirror (
    .va10 (vaddr[10]),
    .va11 (vaddr[11]),
    .sel  (one_scr_sel),
    .strap(mirror_strap),
    .a10  (nt_a10)
  );

  vbus_ce_decode u_ce (
    .va13    (nt_window),
    .four_scr(four_scr_strap),
    .chr_ce_n(chr_ce_n),
    .nt_ce_n (nt_ce_n)
  );

endmodule

// File: rtl/vbus_chr_nt_map_chk.sv
module vbus_chr_nt_map_chk #(
  parameter int VA_W          = 14,
  parameter int PAGE_AW       = 13,
  parameter int MAX_BANK_BITS = 2,
  parameter int CHR_BANK_BITS = 2,
  localparam int CHR_AW       = PAGE_AW + MAX_BANK_BITS
) (
  input logic [VA_W-1:0]          vaddr,
  input logic [MAX_BANK_BITS-1:0] bank_sel,
  input logic                     one_scr_sel,
  input logic [1:0]               mirror_strap,
  input logic                     four_scr_strap,
  input logic [CHR_AW-1:0]        chr_addr,
  input logic                     chr_ce_n,
  input logic                     nt_a10,
  input logic                     nt_ce_n,
  input logic                     page_fold
);

  always_comb begin
    // R1
    assert_offset_pass_R1: assert (chr_addr[PAGE_AW-1:0] == vaddr[PAGE_AW-1:0]);
    // R6
    assert_ce_exclusive_R6: assert (!(chr_ce_n == 1'b0 && nt_ce_n == 1'b0));
    // R7
    if (four_scr_strap) begin
      assert_four_ce_R7: assert (!chr_ce_n && nt_ce_n);
    end
    // R8
    if (page_fold) begin
      assert_fold_top_R8: assert (&chr_addr[CHR_AW-1:PAGE_AW]);
    end
    // R5
    if (mirror_strap[1]) begin
      assert_one_screen_R5: assert (nt_a10 == one_scr_sel);
    end
    // R2
    if (!four_scr_strap && CHR_BANK_BITS == MAX_BANK_BITS) begin
      assert_bank_direct_R2: assert (chr_addr[CHR_AW-1:PAGE_AW] == bank_sel);
    end
    // R10
    for (int i = CHR_BANK_BITS; i < MAX_BANK_BITS; i++) begin
      assert_tied_high_R10: assert (chr_addr[PAGE_AW+i]);
    end
  end

endmodule

bind vbus_chr_nt_map vbus_chr_nt_map_chk #(
  .VA_W         (VA_W),
  .PAGE_AW      (PAGE_AW),
  .MAX_BANK_BITS(MAX_BANK_BITS),
  .CHR_BANK_BITS(CHR_BANK_BITS)
) u_chk (
  .vaddr         (vaddr),
  .bank_sel      (bank_sel),
  .one_scr_sel   (one_scr_sel),
  .mirror_strap  (mirror_strap),
  .four_scr_strap(four_scr_strap),
  .chr_addr      (chr_addr),
  .chr_ce_n      (chr_ce_n),
  .nt_a10        (nt_a10),
  .nt_ce_n       (nt_ce_n),
  .page_fold     (page_fold)
);

// File: tb/vbus_chr_nt_map_tb.sv
module vbus_chr_nt_map_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [13:0] vaddr = '0;
  logic [1:0]  bank_sel = '0;
  logic        one_scr_sel = 1'b0;
  logic [1:0]  mirror_strap = 2'b00;
  logic        four_scr_strap = 1'b0;

  logic [14:0] chr_addr, chr_addr8, chr_addr16;
  logic        chr_ce_n, nt_a10, nt_ce_n;
  logic        ce8, a10_8, nce8, ce16, a10_16, nce16;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;
  bit done    = 1'b0;

  vbus_chr_nt_map u_dut (
    .vaddr(vaddr), .bank_sel(bank_sel), .one_scr_sel(one_scr_sel),
    .mirror_strap(mirror_strap), .four_scr_strap(four_scr_strap),
    .chr_addr(chr_addr), .chr_ce_n(chr_ce_n), .nt_a10(nt_a10), .nt_ce_n(nt_ce_n)
  );

  vbus_chr_nt_map #(.CHR_BANK_BITS(0)) u_dut8 (
    .vaddr(vaddr), .bank_sel(bank_sel), .one_scr_sel(one_scr_sel),
    .mirror_strap(mirror_strap), .four_scr_strap(four_scr_strap),
    .chr_addr(chr_addr8), .chr_ce_n(ce8), .nt_a10(a10_8), .nt_ce_n(nce8)
  );

  vbus_chr_nt_map #(.CHR_BANK_BITS(1)) u_dut16 (
    .vaddr(vaddr), .bank_sel(bank_sel), .one_scr_sel(one_scr_sel),
    .mirror_strap(mirror_strap), .four_scr_strap(four_scr_strap),
    .chr_addr(chr_addr16), .chr_ce_n(ce16), .nt_a10(a10_16), .nt_ce_n(nce16)
  );

  // Reference model, written from the requirements.
  function automatic logic [14:0] ref_addr(input logic [13:0] va, input logic [1:0] bk,
                                           input logic four, input int fitted);
    logic [1:0] pg;
    for (int i = 0; i < 2; i++)
      pg[i] = (i >= fitted) ? 1'b1 : (four && va[13]) ? 1'b1 : bk[i];
    return {pg, va[12:0]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [13:0] va, input logic [1:0] bk, input logic sel,
                       input logic [1:0] ms, input logic four);
    @(negedge clk);
    vaddr = va; bank_sel = bk; one_scr_sel = sel; mirror_strap = ms; four_scr_strap = four;
    #1;
  endtask

  task automatic t_idle();
    apply(14'h0000, 2'b00, 1'b0, 2'b00, 1'b0);
    check("R1 idle addr", 32'(chr_addr), 32'h0);
    check("R6 idle enables", {30'b0, chr_ce_n, nt_ce_n}, 32'b01);
  endtask

  task automatic t_pattern_banks();
    for (int b = 0; b < 4; b++) begin
      apply(14'h1A5C, 2'(b), 1'b0, 2'b01, 1'b0);
      check("R1/R2 pattern", 32'(chr_addr), 32'(ref_addr(14'h1A5C, 2'(b), 1'b0, 2)));
      check("R6 pattern ce", {30'b0, chr_ce_n, nt_ce_n}, 32'b01);
    end
    apply(14'h2C31, 2'b10, 1'b0, 2'b00, 1'b0);
    check("R2 nt window page", 32'(chr_addr[14:13]), 32'b10);
    check("R6 nt window ce", {30'b0, chr_ce_n, nt_ce_n}, 32'b10);
  endtask

  task automatic t_mirror();
    logic [13:0] addrs [4] = '{14'h2000, 14'h2400, 14'h2800, 14'h2C00};
    for (int k = 0; k < 4; k++) begin
      apply(addrs[k], 2'b00, 1'b0, 2'b00, 1'b0);
      check("R3 vertical", 32'(nt_a10), 32'(addrs[k][10]));
      apply(addrs[k], 2'b00, 1'b0, 2'b01, 1'b0);
      check("R4 horizontal", 32'(nt_a10), 32'(addrs[k][11]));
      apply(addrs[k], 2'b00, 1'b1, 2'b10, 1'b0);
      check("R5 one-screen hi", 32'(nt_a10), 32'b1);
      apply(addrs[k], 2'b00, 1'b0, 2'b11, 1'b0);
      check("R5 one-screen alt lo", 32'(nt_a10), 32'b0);
    end
  endtask

  task automatic t_four_screen();
    logic [14:0] seen [5];
    logic [13:0] nts [5] = '{14'h2000, 14'h2400, 14'h2800, 14'h2C00, 14'h3000};
    for (int k = 0; k < 5; k++) begin
      apply(nts[k], 2'b01, 1'b0, 2'b00, 1'b1);
      seen[k] = chr_addr;
      check("R8 fold top", 32'(chr_addr), 32'(ref_addr(nts[k], 2'b01, 1'b1, 2)));
      check("R7 four ce", {30'b0, chr_ce_n, nt_ce_n}, 32'b01);
    end
    for (int i = 0; i < 5; i++)
      for (int j = i + 1; j < 5; j++)
        check("R8 distinct", 32'(seen[i] != seen[j]), 32'b1);
    apply(14'h0123, 2'b10, 1'b0, 2'b00, 1'b1);
    check("R9 pattern uses bank", 32'(chr_addr), 32'h4123);
    check("R7 four ce pattern", {30'b0, chr_ce_n, nt_ce_n}, 32'b01);
  endtask

  task automatic t_alias();
    logic [14:0] lo, hi;
    apply(14'h1F80, 2'b11, 1'b0, 2'b00, 1'b1);
    lo = chr_addr;
    check("R9 hidden tail", 32'(lo), 32'h7F80);
    apply(14'h3F80, 2'b11, 1'b0, 2'b00, 1'b1);
    hi = chr_addr;
    check("R9 alias match", 32'(hi), 32'(lo));
  endtask

  task automatic t_small();
    for (int b = 0; b < 4; b++) begin
      apply(14'h0777, 2'(b), 1'b0, 2'b00, 1'b0);
      check("R10 8k", 32'(chr_addr8), 32'(ref_addr(14'h0777, 2'(b), 1'b0, 0)));
      check("R10 16k", 32'(chr_addr16), 32'(ref_addr(14'h0777, 2'(b), 1'b0, 1)));
      apply(14'h2777, 2'(b), 1'b0, 2'b00, 1'b1);
      check("R10 16k four", 32'(chr_addr16), 32'(ref_addr(14'h2777, 2'(b), 1'b1, 1)));
    end
  endtask

  initial begin
    repeat (200000) begin
      @(posedge clk);
      cycles++;
      if (done) break;
    end
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<200000", cycles);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_idle();
    t_pattern_banks();
    t_mirror();
    t_four_screen();
    t_alias();
    t_small();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule